// File: doc/BRIEF.md
# Register Rename Map with Branch Checkpoints

This block is the renaming step of an out-of-order core. Each cycle it accepts one instruction, translates its two architectural source register numbers into physical register numbers, and gives a writing destination a fresh physical register taken from a circular free queue. The physical register that previously held the destination's value is reported alongside. The consumer keeps that number and hands it back through the return port once the overwriting instruction retires. Returned registers join the back of the queue.

When a branch is renamed, the block takes one checkpoint slot. The slot holds a copy of the map table and the free-queue read pointer as they are after that instruction. If the branch later turns out mispredicted, one restore request puts both copies back in a single cycle. That slot and every younger slot are then discarded. A correctly predicted branch releases the oldest slot instead. Architectural register 0 is hardwired: it always reads as physical 0 and is never given a new register.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free queue holds the physical numbers from ARCH_REGS up to PHYS_REGS-1 in ascending order, so the first three allocations return 8, 9 and 10 with the default sizes.
- R2: `rsp_psrc1` and `rsp_psrc2` show, in the same cycle and combinationally, the current map entry for `ren_src1` and `ren_src2`.
- R3: A rename is accepted when `ren_valid` and `ren_ready` are both high. If it has `ren_dst_we` set with a non-zero destination, `rsp_pdst` is the register at the head of the free queue and `rsp_pold` is the mapping the destination had before this rename.
- R4: A source renamed in the cycle directly after a rename that wrote the same architectural register reads that rename's new physical register.
- R5: Source register 0 always reads physical 0. A rename with destination 0 allocates nothing, and it shows `rsp_pdst` = 0 and `rsp_pold` = 0.
- R6: A register returned through `ret_valid`/`ret_preg` is appended at the tail of the free queue. It is handed out only after every register that was already free.
- R7: `ren_ready` is low while the free queue is empty and the request needs a new register. A request without a destination still proceeds. A register returned in the same cycle does not lift the stall until the next cycle.
- R8: A branch rename (`ren_is_branch`) takes the next checkpoint slot in circular order, starting at 0 after reset. It reports the slot in `rsp_ckpt_id` and records the map and the free-queue head as they stand after this instruction.
- R9: `ck_restore` with `ck_restore_id` brings back that slot's map and free-queue head in one cycle. Registers returned before or during the restore stay free. `ren_ready` is low in the restore cycle.
- R10: A restore discards the named slot and all younger slots, so the next branch receives the restored slot number. A restore overrides a release in the same cycle.
- R11: `ren_ready` is low for a branch while all NUM_CKPT slots are held. `ck_release` frees the oldest slot.
- R12: Successive writes to one architectural register receive distinct physical registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_is_branch | input | 1 | Request is a branch and needs a checkpoint |
| ren_dst_we | input | 1 | Request writes a destination register |
| ren_dst | input | AW | Architectural destination |
| ren_src1 | input | AW | Architectural source 1 |
| ren_src2 | input | AW | Architectural source 2 |
| ren_ready | output | 1 | Request can be accepted this cycle |
| rsp_psrc1 | output | PW | Physical source 1 |
| rsp_psrc2 | output | PW | Physical source 2 |
| rsp_pdst | output | PW | Newly allocated physical destination, 0 if none |
| rsp_pold | output | PW | Previous mapping of the destination |
| rsp_ckpt_id | output | CW | Checkpoint slot given to a branch |
| ret_valid | input | 1 | Physical register being returned |
| ret_preg | input | PW | Returned physical register |
| ck_release | input | 1 | Free the oldest checkpoint slot |
| ck_restore | input | 1 | Restore a checkpoint after a misprediction |
| ck_restore_id | input | CW | Slot to restore |

## Verification
A register return and a checkpoint restore can fall into the same cycle. The restore rewinds the free-queue head while the return advances the tail. The bench makes a wrong-path allocation after a branch, then returns a retired register in the very cycle that the branch's slot is restored. It judges the result by draining the queue: the wrong-path registers must be handed out again first, and the returned register must appear last, after physical 15. A second pairing puts a release and a restore in one cycle. It is judged by the slot number that the next branch receives.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int DEF_ARCH_REGS = 8;
    localparam int DEF_PHYS_REGS = 16;
    localparam int DEF_NUM_CKPT  = 4;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int PHYS_REGS = 16,
    parameter int ARCH_REGS = 8,
    parameter int NUM_CKPT  = 4,
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_preg,
    input  logic          save,
    input  logic [CW-1:0] save_id,
    input  logic          restore,
    input  logic [CW-1:0] restore_id,
    output logic [PW-1:0] head_preg,
    output logic          empty
);
    typedef struct packed {
        logic [PHYS_REGS-1:0][PW-1:0] slot;
        logic [PW:0]                  head;
        logic [PW:0]                  tail;
        logic [NUM_CKPT-1:0][PW:0]    snap;
    } fl_t;

    fl_t s_q, s_d;

    function automatic fl_t fl_reset();
        fl_t r;
        r = '0;
        for (int i = 0; i < PHYS_REGS - ARCH_REGS; i++) begin
            r.slot[i] = PW'(ARCH_REGS + i);
        end
        r.tail = (PW+1)'(PHYS_REGS - ARCH_REGS);
        return r;
    endfunction

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.head = s_q.head + 1'b1;
        end
        if (push) begin
            s_d.slot[s_q.tail[PW-1:0]] = push_preg;
            s_d.tail = s_q.tail + 1'b1;
        end
        if (save) begin
            s_d.snap[save_id] = s_d.head;
        end
        if (restore) begin
            s_d.head = s_q.snap[restore_id];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= fl_reset();
        end else begin
            s_q <= s_d;
        end
    end

    assign head_preg = s_q.slot[s_q.head[PW-1:0]];
    assign empty     = (s_q.head == s_q.tail);
endmodule

// File: rtl/rn_ckpt_ctrl.sv
module rn_ckpt_ctrl #(
    parameter int NUM_CKPT = 4,
    localparam int CW = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          release_oldest,
    input  logic          restore,
    input  logic [CW-1:0] restore_id,
    output logic [CW-1:0] alloc_id,
    output logic          full
);
    typedef struct packed {
        logic [CW-1:0] head;
        logic [CW:0]   cnt;
    } ck_t;

    ck_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (restore) begin
            s_d.cnt = {1'b0, CW'(restore_id - s_q.head)};
        end else begin
            if (release_oldest && s_q.cnt != '0) begin
                s_d.head = s_q.head + 1'b1;
                s_d.cnt  = s_d.cnt - 1'b1;
            end
            if (alloc) begin
                s_d.cnt = s_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_id = s_q.head + s_q.cnt[CW-1:0];
    assign full     = (s_q.cnt == (CW+1)'(NUM_CKPT));
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int NUM_CKPT  = 4,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd1_idx,
    input  logic [AW-1:0] rd2_idx,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_val,
    input  logic          save,
    input  logic [CW-1:0] save_id,
    input  logic          restore,
    input  logic [CW-1:0] restore_id,
    output logic [PW-1:0] rd1_val,
    output logic [PW-1:0] rd2_val,
    output logic [PW-1:0] old_val
);
    typedef logic [ARCH_REGS-1:0][PW-1:0] map_t;

    map_t map_q, map_d;
    logic [NUM_CKPT-1:0][ARCH_REGS-1:0][PW-1:0] snap_bus;

    function automatic map_t map_reset();
        map_t r;
        for (int i = 0; i < ARCH_REGS; i++) begin
            r[i] = PW'(i);
        end
        return r;
    endfunction

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d[wr_idx] = wr_val;
        end
        if (restore) begin
            map_d = snap_bus[restore_id];
        end
        map_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= map_reset();
        end else begin
            map_q <= map_d;
        end
    end

    for (genvar k = 0; k < NUM_CKPT; k++) begin : g_snap
        map_t snap_q, snap_d;
        always_comb begin
            snap_d = snap_q;
            if (save && save_id == CW'(k)) begin
                snap_d = map_d;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q <= map_reset();
            end else begin
                snap_q <= snap_d;
            end
        end
        assign snap_bus[k] = snap_q;
    end

    assign rd1_val = map_q[rd1_idx];
    assign rd2_val = map_q[rd2_idx];
    assign old_val = map_q[wr_idx];
endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
    parameter int PHYS_REGS = rn_pkg::DEF_PHYS_REGS,
    parameter int NUM_CKPT  = rn_pkg::DEF_NUM_CKPT,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(NUM_CKPT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic          ren_is_branch,
    input  logic          ren_dst_we,
    input  logic [AW-1:0] ren_dst,
    input  logic [AW-1:0] ren_src1,
    input  logic [AW-1:0] ren_src2,
    output logic          ren_ready,
    output logic [PW-1:0] rsp_psrc1,
    output logic [PW-1:0] rsp_psrc2,
    output logic [PW-1:0] rsp_pdst,
    output logic [PW-1:0] rsp_pold,
    output logic [CW-1:0] rsp_ckpt_id,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_preg,
    input  logic          ck_release,
    input  logic          ck_restore,
    input  logic [CW-1:0] ck_restore_id
);
    logic          need_reg;
    logic          fire;
    logic          do_alloc;
    logic          do_save;
    logic          fl_empty;
    logic          ck_full;
    logic [PW-1:0] fl_head_preg;
    logic [CW-1:0] ck_alloc_id;

    assign need_reg  = ren_dst_we && (ren_dst != '0);
    assign ren_ready = !ck_restore
                    && !(need_reg && fl_empty)
                    && !(ren_is_branch && ck_full);
    assign fire      = ren_valid && ren_ready;
    assign do_alloc  = fire && need_reg;
    assign do_save   = fire && ren_is_branch;

    rn_freelist #(
        .PHYS_REGS (PHYS_REGS),
        .ARCH_REGS (ARCH_REGS),
        .NUM_CKPT  (NUM_CKPT)
    ) u_fl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (do_alloc),
        .push       (ret_valid),
        .push_preg  (ret_preg),
        .save       (do_save),
        .save_id    (ck_alloc_id),
        .restore    (ck_restore),
        .restore_id (ck_restore_id),
        .head_preg  (fl_head_preg),
        .empty      (fl_empty)
    );

    rn_ckpt_ctrl #(
        .NUM_CKPT (NUM_CKPT)
    ) u_ck (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc          (do_save),
        .release_oldest (ck_release),
        .restore        (ck_restore),
        .restore_id     (ck_restore_id),
        .alloc_id       (ck_alloc_id),
        .full           (ck_full)
    );

    rn_maptable #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .NUM_CKPT  (NUM_CKPT)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd1_idx    (ren_src1),
        .rd2_idx    (ren_src2),
        .wr_idx     (ren_dst),
        .wr_en      (do_alloc),
        .wr_val     (fl_head_preg),
        .save       (do_save),
        .save_id    (ck_alloc_id),
        .restore    (ck_restore),
        .restore_id (ck_restore_id),
        .rd1_val    (rsp_psrc1),
        .rd2_val    (rsp_psrc2),
        .old_val    (rsp_pold)
    );

    assign rsp_pdst    = need_reg ? fl_head_preg : '0;
    assign rsp_ckpt_id = ck_alloc_id;
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
    parameter int AW = 3,
    parameter int PW = 4,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_is_branch,
    input logic          ren_dst_we,
    input logic [AW-1:0] ren_dst,
    input logic [AW-1:0] ren_src1,
    input logic          ren_ready,
    input logic [PW-1:0] rsp_psrc1,
    input logic [PW-1:0] rsp_pdst,
    input logic [CW-1:0] rsp_ckpt_id,
    input logic          ck_restore,
    input logic [CW-1:0] ck_restore_id
);
    logic alloc_now;
    assign alloc_now = ren_valid && ren_ready && ren_dst_we && (ren_dst != '0);

    // R4
    bypass_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_now |=> (ren_src1 != $past(ren_dst)) || (rsp_psrc1 == $past(rsp_pdst)));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src1 == '0) |-> (rsp_psrc1 == '0));

    // R3
    alloc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_now |-> (rsp_pdst != '0));

    // R12
    distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_now |=> !alloc_now || (rsp_pdst != $past(rsp_pdst)));

    // R10
    restore_slot_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_restore |=> !(ren_valid && ren_ready && ren_is_branch)
                       || (rsp_ckpt_id == $past(ck_restore_id)));
endmodule

bind rename_map rename_map_chk #(.AW(AW), .PW(PW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_valid     (ren_valid),
    .ren_is_branch (ren_is_branch),
    .ren_dst_we    (ren_dst_we),
    .ren_dst       (ren_dst),
    .ren_src1      (ren_src1),
    .ren_ready     (ren_ready),
    .rsp_psrc1     (rsp_psrc1),
    .rsp_pdst      (rsp_pdst),
    .rsp_ckpt_id   (rsp_ckpt_id),
    .ck_restore    (ck_restore),
    .ck_restore_id (ck_restore_id)
);

// File: tb/rename_map_test.sv
module rename_map_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_is_branch = 1'b0, ren_dst_we = 1'b0;
    logic [2:0] ren_dst = '0, ren_src1 = '0, ren_src2 = '0;
    logic       ren_ready;
    logic [3:0] rsp_psrc1, rsp_psrc2, rsp_pdst, rsp_pold;
    logic [1:0] rsp_ckpt_id;
    logic       ret_valid = 1'b0;
    logic [3:0] ret_preg = '0;
    logic       ck_release = 1'b0, ck_restore = 1'b0;
    logic [1:0] ck_restore_id = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rename_map uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_is_branch(ren_is_branch), .ren_dst_we(ren_dst_we),
        .ren_dst(ren_dst), .ren_src1(ren_src1), .ren_src2(ren_src2),
        .ren_ready(ren_ready), .rsp_psrc1(rsp_psrc1), .rsp_psrc2(rsp_psrc2),
        .rsp_pdst(rsp_pdst), .rsp_pold(rsp_pold), .rsp_ckpt_id(rsp_ckpt_id),
        .ret_valid(ret_valid), .ret_preg(ret_preg),
        .ck_release(ck_release), .ck_restore(ck_restore), .ck_restore_id(ck_restore_id)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ren_valid = 0; ren_is_branch = 0; ren_dst_we = 0;
        ret_valid = 0; ck_release = 0; ck_restore = 0;
    endtask

    task automatic ren(input bit we, input int dst, input int s1, input int s2, input bit br);
        @(negedge clk);
        ret_valid = 0; ck_release = 0; ck_restore = 0;
        ren_valid = 1; ren_dst_we = we; ren_is_branch = br;
        ren_dst = 3'(dst); ren_src1 = 3'(s1); ren_src2 = 3'(s2);
        #1;
    endtask

    task automatic t_reset();
        ren(1, 3, 3, 7, 0);
        ren_valid = 0;
        chk("R1 ready after reset", int'(ren_ready), 1);
        chk("R1 r3 maps to p3", int'(rsp_psrc1), 3);
        chk("R2 r7 maps to p7", int'(rsp_psrc2), 7);
        chk("R1 first free is 8", int'(rsp_pdst), 8);
    endtask

    task automatic t_basic();
        ren(1, 1, 1, 2, 0);
        chk("R2 src1", int'(rsp_psrc1), 1);
        chk("R2 src2", int'(rsp_psrc2), 2);
        chk("R3 pdst", int'(rsp_pdst), 8);
        chk("R3 pold", int'(rsp_pold), 1);
        ren(1, 1, 1, 3, 0);
        chk("R4 bypass src1", int'(rsp_psrc1), 8);
        chk("R12 second write distinct", int'(rsp_pdst), 9);
        chk("R3 pold is prior new", int'(rsp_pold), 8);
    endtask

    task automatic t_zero();
        ren(1, 0, 0, 1, 0);
        chk("R5 ready for r0 dst", int'(ren_ready), 1);
        chk("R5 src r0", int'(rsp_psrc1), 0);
        chk("R5 pdst for r0", int'(rsp_pdst), 0);
        chk("R5 pold for r0", int'(rsp_pold), 0);
        ren(1, 2, 2, 0, 0);
        chk("R5 r0 took no register", int'(rsp_pdst), 10);
    endtask

    task automatic t_branch_restore();
        ren(0, 0, 1, 2, 1);
        chk("R8 branch slot", int'(rsp_ckpt_id), 0);
        chk("R8 branch ready", int'(ren_ready), 1);
        ren(1, 1, 0, 0, 0);
        chk("R3 wrong-path pdst", int'(rsp_pdst), 11);
        ren(1, 3, 1, 0, 0);
        chk("R4 wrong-path bypass", int'(rsp_psrc1), 11);
        chk("R3 wrong-path pdst 2", int'(rsp_pdst), 12);
        // restore slot 0 and return p1 in the same cycle
        ren(1, 5, 0, 0, 0);
        ck_restore = 1; ck_restore_id = 2'd0;
        ret_valid = 1; ret_preg = 4'd1;
        #1;
        chk("R9 ready low during restore", int'(ren_ready), 0);
        ren(1, 4, 1, 3, 0);
        chk("R9 map r1 restored", int'(rsp_psrc1), 9);
        chk("R9 map r3 restored", int'(rsp_psrc2), 3);
        chk("R9 head restored", int'(rsp_pdst), 11);
        chk("R9 pold of r4", int'(rsp_pold), 4);
    endtask

    task automatic t_empty();
        int exp_seq[5] = '{12, 13, 14, 15, 1};
        int dsts[5] = '{5, 6, 7, 5, 6};
        for (int i = 0; i < 5; i++) begin
            ren(1, dsts[i], 0, 0, 0);
            chk("R6 order incl returned reg last", int'(rsp_pdst), exp_seq[i]);
        end
        ren(1, 7, 0, 0, 0);
        ret_valid = 1; ret_preg = 4'd2;
        #1;
        chk("R7 stall when empty", int'(ren_ready), 0);
        ren(0, 7, 6, 0, 0);
        chk("R7 no-dst proceeds", int'(ren_ready), 1);
        chk("R2 r6 lookup", int'(rsp_psrc1), 1);
        ren(1, 7, 0, 0, 0);
        chk("R7 ready after return", int'(ren_ready), 1);
        chk("R6 returned reg used", int'(rsp_pdst), 2);
        ren(1, 5, 0, 0, 0);
        chk("R7 empty again", int'(ren_ready), 0);
        idle();
    endtask

    task automatic t_ckpt();
        for (int i = 0; i < 4; i++) begin
            ren(0, 0, 0, 0, 1);
            chk("R8 slot order", int'(rsp_ckpt_id), i);
        end
        ren(0, 0, 0, 0, 1);
        chk("R11 stall when slots full", int'(ren_ready), 0);
        idle();
        ck_restore = 1; ck_restore_id = 2'd2;
        ren(0, 0, 0, 0, 1);
        chk("R10 restored slot reused", int'(rsp_ckpt_id), 2);
        idle();
        ck_release = 1;
        ren(0, 0, 0, 0, 1);
        chk("R11 after release", int'(rsp_ckpt_id), 3);
        ren(0, 0, 0, 0, 1);
        chk("R8 slot wraps", int'(rsp_ckpt_id), 0);
        ren(0, 0, 0, 0, 1);
        chk("R11 full after release cycle", int'(ren_ready), 0);
        idle();
        ck_restore = 1; ck_restore_id = 2'd1; ck_release = 1;
        ren(0, 0, 0, 0, 1);
        chk("R10 restore overrides release", int'(rsp_ckpt_id), 1);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_zero();
        t_branch_restore();
        t_empty();
        t_ckpt();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule